// File: doc/BRIEF.md
# Base-Selectable I/O Select Decoder

This block turns the host I/O address into active-low select strobes for the ports of a small peripheral bus. A 4-bit switch value picks the base of a 32-port window. Address bits 5 to 8 must equal the switch value for anything to be selected. Host DMA cycles, flagged by AEN high, never select anything, and neither does an address with no read or write strobe. The low five address bits are the offset into the window.

The window is split by function. Offsets 0 to 3 serve the interrupt controller: two controller ports, the register that picks which host interrupt line is used, and the acknowledge port. Offsets 4 to 7 are the clock-generator registers of slots 0 to 3. Offsets 8 to 10 are the shared-memory low count, high count and mode/direction registers. Offsets 11 to 15 are left empty. The upper half of the window gives each of the four expansion slots four consecutive port selects. Each decoded select is captured in a register on the clock edge and shows on the outputs one cycle later.

Top module: `io_sel_decoder`

## Requirements
- R1: While rst_ni is low, every select output is high (inactive).
- R2: A select can go low only if addr_i[8:5] equals base_sw_i. A mismatch leaves every select high.
- R3: Each select output is registered. Inputs sampled at a rising edge set the outputs that hold until the next edge. At most one select is low at any time.
- R4: On a valid access to offsets 0 to 3 (addr_i[4:0]), irq_sel_no[offset] goes low: bit 0 is controller port 0, bit 1 is controller port 1, bit 2 is the interrupt-line choice, bit 3 is the acknowledge port.
- R5: On a valid access to offsets 4 to 7, clk_sel_no[offset-4] goes low. Bit n is the clock register of slot n.
- R6: On a valid access to offsets 8, 9 and 10, mem_sel_no bit 0, 1 or 2 goes low. These are the low count, high count and mode/direction registers, in that order.
- R7: Offsets 11 to 15 select nothing. Every output stays high.
- R8: On a valid access to offset 16+4*s+p (s = slot 0..3, p = port 0..3), slot_sel_no[4*s+p] goes low.
- R9: While aen_i is high, every select stays high, whatever the address.
- R10: A select goes low only when ior_ni or iow_ni is low. Either strobe alone is enough. With both high, every select stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 9 | Host I/O address bits 8..0 |
| aen_i | input | 1 | DMA address enable, high during DMA cycles |
| ior_ni | input | 1 | I/O read strobe, active low |
| iow_ni | input | 1 | I/O write strobe, active low |
| base_sw_i | input | 4 | Base switch setting compared with addr_i[8:5] |
| irq_sel_no | output | 4 | Interrupt-controller port selects, active low |
| clk_sel_no | output | 4 | Per-slot clock register selects, active low |
| mem_sel_no | output | 3 | Shared-memory register selects, active low |
| slot_sel_no | output | 16 | Four port selects per slot, active low |

## Verification
The assertions check on every cycle that at most one select is low. They also check that a select is never low after a cycle with AEN high, with no strobe, with a base mismatch, or with an offset in the empty gap, and that a qualified access to a populated offset gives exactly one low select. Only the bench's scenarios show that each offset reaches the right group and bit, that each strobe alone is enough, and that the reset value holds while inputs are active. To do this the bench sweeps all 32 offsets and compares random traffic against its own model.

// File: rtl/io_sel_pkg.sv
package io_sel_pkg;
  localparam int SW_W      = 4;
  localparam int BASE_LSB  = 5;
  localparam int ADDR_W    = BASE_LSB + SW_W;
  localparam int DEC_W     = 4;
  localparam int NUM_DEC   = 2;
  localparam int WIN_W     = DEC_W + $clog2(NUM_DEC);
  localparam int WIN_N     = 1 << WIN_W;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_PRT  = 4;
  // fixed functional layout of the window
  localparam int OFF_IRQ   = 0;
  localparam int N_IRQ     = 4;
  localparam int OFF_CLK   = 4;
  localparam int OFF_MEM   = 8;
  localparam int N_MEM     = 3;
  localparam int OFF_GAP   = OFF_MEM + N_MEM;
  localparam int OFF_SLOT  = 16;
  localparam int N_SLOT    = NUM_SLOTS * SLOT_PRT;
endpackage

// File: rtl/io_base_match.sv
module io_base_match #(
  parameter int SW_W     = 4,
  parameter int BASE_LSB = 5
) (
  input  logic [SW_W-1:0] base_bits_i,
  input  logic [SW_W-1:0] base_sw_i,
  input  logic            aen_i,
  input  logic            ior_ni,
  input  logic            iow_ni,
  output logic            hit_o
);
  logic strobe;
  assign strobe = ~ior_ni | ~iow_ni;
  assign hit_o  = (base_bits_i == base_sw_i) & ~aen_i & strobe;
endmodule

// File: rtl/io_dec16.sv
module io_dec16 #(
  parameter int DEC_W = 4,
  localparam int N    = 1 << DEC_W
) (
  input  logic             en_i,
  input  logic [DEC_W-1:0] idx_i,
  output logic [N-1:0]     sel_no
);
  for (genvar i = 0; i < N; i++) begin : g_out
    assign sel_no[i] = ~(en_i && (idx_i == DEC_W'(i)));
  end
endmodule

// File: rtl/io_sel_decoder.sv
module io_sel_decoder
  import io_sel_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           aen_i,
  input  logic                           ior_ni,
  input  logic                           iow_ni,
  input  logic [SW_W-1:0]                base_sw_i,
  output logic [N_IRQ-1:0]               irq_sel_no,
  output logic [NUM_SLOTS-1:0]           clk_sel_no,
  output logic [N_MEM-1:0]               mem_sel_no,
  output logic [N_SLOT-1:0]              slot_sel_no
);
  localparam int DEC_N  = 1 << DEC_W;
  localparam int BANK_W = WIN_W - DEC_W;

  logic             hit;
  logic [WIN_N-1:0] win_n;
  logic             gap_unused;

  io_base_match #(.SW_W(SW_W), .BASE_LSB(BASE_LSB)) u_match (
    .base_bits_i (addr_i[ADDR_W-1:BASE_LSB]),
    .base_sw_i   (base_sw_i),
    .aen_i       (aen_i),
    .ior_ni      (ior_ni),
    .iow_ni      (iow_ni),
    .hit_o       (hit)
  );

  for (genvar d = 0; d < NUM_DEC; d++) begin : g_bank
    logic bank_en;
    assign bank_en = hit && (addr_i[WIN_W-1:DEC_W] == BANK_W'(d));
    io_dec16 #(.DEC_W(DEC_W)) u_dec (
      .en_i   (bank_en),
      .idx_i  (addr_i[DEC_W-1:0]),
      .sel_no (win_n[d*DEC_N +: DEC_N])
    );
  end

  // offsets between the shared-memory group and the slot quads are unpopulated
  assign gap_unused = &win_n[OFF_SLOT-1:OFF_GAP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_sel_no  <= '1;
      clk_sel_no  <= '1;
      mem_sel_no  <= '1;
      slot_sel_no <= '1;
    end else begin
      irq_sel_no  <= win_n[OFF_IRQ +: N_IRQ];
      clk_sel_no  <= win_n[OFF_CLK +: NUM_SLOTS];
      mem_sel_no  <= win_n[OFF_MEM +: N_MEM];
      slot_sel_no <= win_n[OFF_SLOT +: N_SLOT];
    end
  end
endmodule

// File: rtl/io_sel_dec_chk.sv
module io_sel_dec_chk
  import io_sel_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 aen_i,
  input logic                 ior_ni,
  input logic                 iow_ni,
  input logic [SW_W-1:0]      base_sw_i,
  input logic [N_IRQ-1:0]     irq_sel_no,
  input logic [NUM_SLOTS-1:0] clk_sel_no,
  input logic [N_MEM-1:0]     mem_sel_no,
  input logic [N_SLOT-1:0]    slot_sel_no
);
  logic [N_IRQ+NUM_SLOTS+N_MEM+N_SLOT-1:0] act;
  logic [4:0] off;
  logic       qual;
  logic       in_gap;
  assign act    = ~{slot_sel_no, mem_sel_no, clk_sel_no, irq_sel_no};
  assign off    = addr_i[4:0];
  assign qual   = !aen_i && !(ior_ni && iow_ni) && (addr_i[8:5] == base_sw_i);
  assign in_gap = (off >= 5'd11) && (off <= 5'd15);

  assert_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act));
  assert_dma_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(aen_i) |-> (act == '0));
  assert_no_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ior_ni && iow_ni) |-> (act == '0));
  assert_base_miss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(addr_i[8:5] != base_sw_i) |-> (act == '0));
  assert_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(in_gap) |-> (act == '0));
  assert_single_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && qual && !in_gap) |-> ($countones(act) == 1));
endmodule

bind io_sel_decoder io_sel_dec_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .aen_i       (aen_i),
  .ior_ni      (ior_ni),
  .iow_ni      (iow_ni),
  .base_sw_i   (base_sw_i),
  .irq_sel_no  (irq_sel_no),
  .clk_sel_no  (clk_sel_no),
  .mem_sel_no  (mem_sel_no),
  .slot_sel_no (slot_sel_no)
);

// File: tb/tb_io_sel_decoder.sv
module tb_io_sel_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 1234;

  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic [8:0] addr_i = '0;
  logic       aen_i = 0;
  logic       ior_ni = 1;
  logic       iow_ni = 1;
  logic [3:0] base_sw_i = '0;
  logic [3:0]  irq_sel_no;
  logic [3:0]  clk_sel_no;
  logic [2:0]  mem_sel_no;
  logic [15:0] slot_sel_no;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  io_sel_decoder dut (.*);

  function automatic logic [26:0] exp_f(logic [8:0] a, logic aen, logic rn, logic wn, logic [3:0] sw);
    logic [26:0] v = '1;
    int o = int'(a[4:0]);
    if (!aen && (!rn || !wn) && a[8:5] == sw) begin
      if (o < 11) v[o] = 1'b0;
      else if (o >= 16) v[o-5] = 1'b0;
    end
    return v;
  endfunction

  function automatic string tag_f(logic [8:0] a, logic aen, logic rn, logic wn, logic [3:0] sw);
    int o = int'(a[4:0]);
    if (aen) return "R9";
    if (rn && wn) return "R10";
    if (a[8:5] != sw) return "R2";
    if (o < 4) return "R4";
    if (o < 8) return "R5";
    if (o < 11) return "R6";
    if (o < 16) return "R7";
    return "R8";
  endfunction

  task automatic check(string tag, logic [26:0] exp);
    logic [26:0] got = {slot_sel_no, mem_sel_no, clk_sel_no, irq_sel_no};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(logic [8:0] a, logic aen, logic rn, logic wn, logic [3:0] sw, string tag);
    @(negedge clk_i);
    addr_i = a; aen_i = aen; ior_ni = rn; iow_ni = wn; base_sw_i = sw;
    @(posedge clk_i);
    #1;
    check(tag, exp_f(a, aen, rn, wn, sw));
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(SEED));
    // R1: reset holds outputs inactive despite a qualified access
    addr_i = {4'd3, 5'd0}; base_sw_i = 4'd3; ior_ni = 0;
    repeat (3) @(posedge clk_i);
    #1 check("R1", '1);
    @(negedge clk_i) rst_ni = 1;
    // R4..R8, R3: sweep every offset, read then write
    for (int o = 0; o < 32; o++) begin
      apply({4'd3, 5'(o)}, 0, 0, 1, 4'd3, tag_f({4'd3, 5'(o)}, 0, 0, 1, 4'd3));
      apply({4'd3, 5'(o)}, 0, 1, 0, 4'd3, "R10");
    end
    // R3: one-cycle latency, deselect on next idle cycle
    apply({4'd9, 5'd18}, 0, 0, 1, 4'd9, "R8");
    apply({4'd9, 5'd18}, 0, 1, 1, 4'd9, "R3");
    // R9: DMA cycle suppresses
    apply({4'd9, 5'd5}, 1, 0, 0, 4'd9, "R9");
    // R2: neighbouring base values miss
    apply({4'd8, 5'd5}, 0, 0, 1, 4'd9, "R2");
    apply({4'd10, 5'd0}, 0, 0, 1, 4'd9, "R2");
    apply({4'd15, 5'd31}, 0, 0, 0, 4'd15, "R8");
    apply({4'd0, 5'd9}, 0, 1, 0, 4'd0, "R6");
    // random traffic, biased toward base hits
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] sw = 4'($urandom);
      logic [8:0] a = 9'($urandom);
      logic aen = ($urandom % 8) == 0;
      logic rn = 1'($urandom);
      logic wn = 1'($urandom);
      if ($urandom % 4 != 0) a[8:5] = sw;
      apply(a, aen, rn, wn, sw, tag_f(a, aen, rn, wn, sw));
    end
    // R1: asynchronous reset returns outputs to inactive
    apply({4'd2, 5'd20}, 0, 0, 1, 4'd2, "R8");
    #2 rst_ni = 0;
    #1 check("R1", '1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule